// File: doc/BRIEF.md
# Processor Exception Entry Unit

This block turns one exception request into the state changes a core needs to enter the handler. The request carries a cause code and an error code. On entry the block stores a return address and a saved copy of the status word, builds the handler's status word, and drives the handler address as the next fetch address. A separate strobe takes the return path, which restores the fetch address and the status word from the saved pair.

The core's register file, fetch unit and address translation sit outside the block. Hypervisor mode is never entered. The current status word and the address of the next instruction come in as inputs. A cause-indexed table of handler offsets is loaded when reset is asserted. A machine check taken while machine checks are disabled stops the block in a checkstop state, which only reset clears.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset, done, vec_err and halted are 0, and fetch_pc, new_msr, save_pc and save_msr are all 0. The offset table is loaded with offset (cause+1)<<8 for each cause. Causes 0 to 12 are marked defined and causes 13 to 15 are marked undefined.
- R2: On entry, save_msr is cur_msr with the bits in mask 0x783F0000 cleared, ORed with the cause's own bits. When embedded_mode is 1, cur_msr is saved without the mask.
- R3: new_msr keeps only the machine-check-enable bit (bit 12) of cur_msr, and sets the little-endian bit (bit 0) when the interrupt-little-endian bit (bit 16) of cur_msr is 1. Machine check (cause 1) clears bit 12. Reset (cause 0) clears bit 12 when the power-save bit (bit 18) is 0.
- R4: Causes 6 (program), 7 (FP unavailable), 11 (vector unavailable) and 12 (facility unavailable) set save_pc to cur_pc-4. Every other cause sets save_pc to cur_pc.
- R5: For cause 6, req_err[1:0] selects the sub-cause, and each sub-cause ORs its own bits into save_msr. Sub-cause 0 is the FP-enabled exception: it ORs 0x00100000, plus 0x00010000 when FE0 (bit 11) differs from FE1 (bit 8). Sub-cause 1 (illegal) ORs 0x00080000, sub-cause 2 (privileged) ORs 0x00040000 and sub-cause 3 (trap) ORs 0x00020000.
- R6: An FP-enabled program exception is dropped when FE0 and FE1 are both 0, or when the FP-available bit (bit 13) is 0. A dropped exception raises no done and leaves every output unchanged.
- R7: A machine check (cause 1) that arrives while bit 12 of cur_msr is 0 sets halted and does not vector. While halted is 1, requests and return strobes are ignored, and only reset clears halted.
- R8: On entry, fetch_pc is vec_base ORed with the table offset for the cause. A request whose cause is undefined pulses vec_err for one cycle and changes no other output.
- R9: A reset entry (cause 0) taken with the power-save bit (bit 18) set ORs 0x00010000 into save_msr.
- R10: A return strobe, with no request in the same cycle, sets fetch_pc to save_pc with bits 1:0 cleared, and sets new_msr to save_msr ANDed with the inverse of 0x783F0000.
- R11: All results are registered. They appear in the cycle after the strobe, and done is high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Exception request strobe |
| req_cause | input | CAUSE_W | Cause code |
| req_err | input | XLEN | Error code; bits 1:0 hold the program sub-cause |
| rfi_valid | input | 1 | Return-from-interrupt strobe |
| embedded_mode | input | 1 | Save the status word without the mask |
| cur_pc | input | XLEN | Address of the next instruction |
| cur_msr | input | XLEN | Current status word |
| vec_base | input | XLEN | Handler base prefix |
| done | output | 1 | Entry or return completed |
| vec_err | output | 1 | Request named an undefined vector |
| halted | output | 1 | Checkstop state |
| fetch_pc | output | XLEN | Next fetch address |
| new_msr | output | XLEN | Status word for the handler or return target |
| save_pc | output | XLEN | Saved return address |
| save_msr | output | XLEN | Saved status word |

## Verification
Every result is one register stage behind its strobe. That covers done, vec_err, halted, fetch_pc, new_msr, save_pc and save_msr. The bench drives the strobe at a falling edge and removes it at the next falling edge. It compares every output at that second falling edge, which is the first point after the capturing rising edge. To check that done lasts one cycle, the bench samples again one falling edge later. Dropped, undefined and halted requests are checked at the same point, by confirming that the saved pair and the fetch address still hold their earlier values.

// File: rtl/exc_entry_unit.sv
module exc_entry_unit #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 4,
  parameter int VEC_SH  = 8,
  parameter logic [(1<<CAUSE_W)-1:0] VEC_DEFINED = 16'h1FFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [CAUSE_W-1:0] req_cause,
  input  logic [XLEN-1:0]    req_err,
  input  logic               rfi_valid,
  input  logic               embedded_mode,
  input  logic [XLEN-1:0]    cur_pc,
  input  logic [XLEN-1:0]    cur_msr,
  input  logic [XLEN-1:0]    vec_base,
  output logic               done,
  output logic               vec_err,
  output logic               halted,
  output logic [XLEN-1:0]    fetch_pc,
  output logic [XLEN-1:0]    new_msr,
  output logic [XLEN-1:0]    save_pc,
  output logic [XLEN-1:0]    save_msr
);
  localparam int NCAUSE = 1 << CAUSE_W;
  localparam logic [XLEN-1:0] SAVE_MASK = XLEN'(32'h783F_0000);
  localparam int B_LE = 0, B_FE1 = 8, B_FE0 = 11, B_ME = 12, B_FP = 13, B_ILE = 16, B_POW = 18;
  localparam logic [CAUSE_W-1:0] C_RESET = 0, C_MCHK = 1, C_EXT = 4, C_PROG = 6,
                                 C_FPU = 7, C_VEC = 11, C_FAC = 12;

  logic [XLEN-1:0] vec_q [NCAUSE];
  logic [NCAUSE-1:0] vec_ok_q;

  logic done_q, vec_err_q, halt_q;
  logic [XLEN-1:0] fetch_q, msr_q, srr0_q, srr1_q;

  wire take      = req_valid && !halt_q;
  wire rfi_go    = rfi_valid && !req_valid && !halt_q;
  wire is_prog   = req_cause == C_PROG;
  wire [1:0] sub = req_err[1:0];
  wire fe0       = cur_msr[B_FE0];
  wire fe1       = cur_msr[B_FE1];
  wire fp_drop   = is_prog && sub == 2'd0 && ((!fe0 && !fe1) || !cur_msr[B_FP]);
  wire ckstop    = req_cause == C_MCHK && !cur_msr[B_ME];
  wire vec_bad   = !vec_ok_q[req_cause];
  wire entry_w   = take && !ckstop && !vec_bad && !fp_drop;
  wire save_cur  = req_cause == C_PROG || req_cause == C_FPU ||
                   req_cause == C_VEC  || req_cause == C_FAC;

  logic [XLEN-1:0] sub_bits;
  always_comb begin
    sub_bits = '0;
    if (is_prog) begin
      case (sub)
        2'd0: sub_bits = XLEN'(32'h0010_0000) | ((fe0 != fe1) ? XLEN'(32'h0001_0000) : '0);
        2'd1: sub_bits = XLEN'(32'h0008_0000);
        2'd2: sub_bits = XLEN'(32'h0004_0000);
        default: sub_bits = XLEN'(32'h0002_0000);
      endcase
    end else if (req_cause == C_RESET && cur_msr[B_POW]) begin
      sub_bits = XLEN'(32'h0001_0000);
    end
  end

  wire [XLEN-1:0] stat_base = embedded_mode ? cur_msr : (cur_msr & ~SAVE_MASK);
  wire me_keep = cur_msr[B_ME] && req_cause != C_MCHK &&
                 !(req_cause == C_RESET && !cur_msr[B_POW]);
  wire [XLEN-1:0] entry_msr = (XLEN'(me_keep) << B_ME) | (XLEN'(cur_msr[B_ILE]) << B_LE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q    <= 1'b0;
      vec_err_q <= 1'b0;
      halt_q    <= 1'b0;
      fetch_q   <= '0;
      msr_q     <= '0;
      srr0_q    <= '0;
      srr1_q    <= '0;
      for (int i = 0; i < NCAUSE; i++) begin
        vec_q[i]    <= XLEN'(i + 1) << VEC_SH;
        vec_ok_q[i] <= VEC_DEFINED[i];
      end
    end else begin
      done_q    <= 1'b0;
      vec_err_q <= 1'b0;
      if (take) begin
        if (ckstop) begin
          halt_q <= 1'b1;
        end else if (vec_bad) begin
          vec_err_q <= 1'b1;
        end else if (!fp_drop) begin
          srr0_q  <= save_cur ? cur_pc - XLEN'(4) : cur_pc;
          srr1_q  <= stat_base | sub_bits;
          msr_q   <= entry_msr;
          fetch_q <= vec_base | vec_q[req_cause];
          done_q  <= 1'b1;
        end
      end else if (rfi_go) begin
        fetch_q <= srr0_q & ~XLEN'(3);
        msr_q   <= srr1_q & ~SAVE_MASK;
        done_q  <= 1'b1;
      end
    end
  end

  assign done     = done_q;
  assign vec_err  = vec_err_q;
  assign halted   = halt_q;
  assign fetch_pc = fetch_q;
  assign new_msr  = msr_q;
  assign save_pc  = srr0_q;
  assign save_msr = srr1_q;

  assert_stat_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    entry_w && !embedded_mode && req_cause == C_EXT |=> (save_msr & SAVE_MASK) == '0);
  assert_newmsr_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    entry_w |=> (new_msr & ~((XLEN'(1) << B_ME) | (XLEN'(1) << B_LE))) == '0);
  assert_mchk_me_R3: assert property (@(posedge clk) disable iff (!rst_n)
    entry_w && req_cause == C_MCHK |=> !new_msr[B_ME]);
  assert_drop_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take && fp_drop && !vec_bad |=> !done && $stable(save_pc) && $stable(save_msr));
  assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && !done);
  assert_vec_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take && !ckstop && vec_bad |=> vec_err && !done && $stable(fetch_pc));
  assert_rfi_align_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rfi_go |=> done && fetch_pc[1:0] == 2'b00);
  assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && vec_err));
endmodule

// File: tb/exc_entry_unit_bench.sv
module exc_entry_unit_bench;
  localparam int XLEN = 32;
  localparam logic [31:0] MASK = 32'h783F_0000;
  localparam logic [31:0] BASE = 32'hFFF0_0000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, rfi_valid = 0, embedded_mode = 0;
  logic [3:0] req_cause = 0;
  logic [31:0] req_err = 0, cur_pc = 0, cur_msr = 0, vec_base = BASE;
  logic done, vec_err, halted;
  logic [31:0] fetch_pc, new_msr, save_pc, save_msr;

  int checks = 0, fails = 0, cycles = 0;

  always #4 clk = ~clk;

  exc_entry_unit u_exc_entry_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cause(req_cause),
    .req_err(req_err), .rfi_valid(rfi_valid), .embedded_mode(embedded_mode),
    .cur_pc(cur_pc), .cur_msr(cur_msr), .vec_base(vec_base), .done(done),
    .vec_err(vec_err), .halted(halted), .fetch_pc(fetch_pc), .new_msr(new_msr),
    .save_pc(save_pc), .save_msr(save_msr));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_save_msr(logic [31:0] m, int c, int s, bit emb);
    logic [31:0] r = emb ? m : (m & ~MASK);
    if (c == 6) begin
      if (s == 0) r |= 32'h0010_0000 | ((m[11] != m[8]) ? 32'h0001_0000 : 32'h0);
      else if (s == 1) r |= 32'h0008_0000;
      else if (s == 2) r |= 32'h0004_0000;
      else r |= 32'h0002_0000;
    end
    if (c == 0 && m[18]) r |= 32'h0001_0000;
    return r;
  endfunction

  function automatic logic [31:0] exp_new_msr(logic [31:0] m, int c);
    logic me = m[12];
    if (c == 1) me = 0;
    if (c == 0 && !m[18]) me = 0;
    return (32'(me) << 12) | 32'(m[16]);
  endfunction

  task automatic drive_req(int c, logic [31:0] err, logic [31:0] pc, logic [31:0] msr, bit emb);
    @(negedge clk);
    req_valid = 1; req_cause = 4'(c); req_err = err; cur_pc = pc; cur_msr = msr; embedded_mode = emb;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic entry_case(string req, int c, logic [31:0] err, logic [31:0] pc,
                            logic [31:0] msr, bit emb);
    bit cur = (c == 6 || c == 7 || c == 11 || c == 12);
    drive_req(c, err, pc, msr, emb);
    chk("R11", "done", 32'(done), 1);
    chk(req, "save_pc R4", save_pc, cur ? pc - 4 : pc);
    chk(req, "save_msr R2", save_msr, exp_save_msr(msr, c, int'(err[1:0]), emb));
    chk(req, "new_msr R3", new_msr, exp_new_msr(msr, c));
    chk(req, "fetch_pc R8", fetch_pc, BASE | (32'(c + 1) << 8));
  endtask

  task automatic t_reset_state;
    chk("R1", "done", 32'(done), 0);
    chk("R1", "vec_err", 32'(vec_err), 0);
    chk("R1", "halted", 32'(halted), 0);
    chk("R1", "fetch_pc", fetch_pc, 0);
    chk("R1", "new_msr", new_msr, 0);
    chk("R1", "save_pc", save_pc, 0);
    chk("R1", "save_msr", save_msr, 0);
  endtask

  task automatic t_external;
    entry_case("R2", 4, 0, 32'h0000_2000, 32'hFFFF_FFFF, 0);
    @(negedge clk);
    chk("R11", "done one cycle", 32'(done), 0);
  endtask

  task automatic t_embedded;
    entry_case("R2", 8, 0, 32'h0000_4000, 32'h7830_1000, 1);
    entry_case("R3", 9, 0, 32'h0000_4100, 32'h0000_0000, 0);
  endtask

  task automatic t_program;
    for (int s = 0; s < 4; s++)
      entry_case("R5", 6, 32'(s), 32'h0000_5000 + 32'(s * 16), 32'h0000_3800, 0);
    entry_case("R5", 6, 0, 32'h0000_5100, 32'h0000_3900, 0);
  endtask

  task automatic t_unavail;
    entry_case("R4", 7, 0, 32'h0000_6000, 32'h0001_1000, 0);
    entry_case("R4", 11, 0, 32'h0000_6100, 32'h0000_1000, 0);
    entry_case("R4", 12, 0, 32'h0000_6200, 32'h0000_1000, 0);
    entry_case("R4", 3, 0, 32'h0000_6300, 32'h0000_1000, 0);
  endtask

  task automatic t_fp_drop;
    logic [31:0] sp = save_pc, sm = save_msr, fp = fetch_pc;
    drive_req(6, 0, 32'h0000_7000, 32'h0000_1800, 0);
    chk("R6", "done (FP off)", 32'(done), 0);
    chk("R6", "save_pc", save_pc, sp);
    chk("R6", "save_msr", save_msr, sm);
    drive_req(6, 0, 32'h0000_7100, 32'h0000_3000, 0);
    chk("R6", "done (modes zero)", 32'(done), 0);
    chk("R6", "fetch_pc", fetch_pc, fp);
  endtask

  task automatic t_sysreset;
    entry_case("R9", 0, 0, 32'h0000_8000, 32'h0004_1000, 0);
    entry_case("R3", 0, 0, 32'h0000_8100, 32'h0000_1000, 0);
    entry_case("R3", 1, 0, 32'h0000_8200, 32'h0001_1000, 0);
  endtask

  task automatic t_undefined;
    logic [31:0] sp = save_pc, fp = fetch_pc;
    drive_req(14, 0, 32'h0000_9000, 32'h0000_1000, 0);
    chk("R8", "vec_err", 32'(vec_err), 1);
    chk("R8", "done", 32'(done), 0);
    chk("R8", "save_pc", save_pc, sp);
    chk("R8", "fetch_pc", fetch_pc, fp);
    @(negedge clk);
    chk("R8", "vec_err pulse", 32'(vec_err), 0);
  endtask

  task automatic t_rfi;
    logic [31:0] sm;
    entry_case("R10", 6, 3, 32'h0000_3003, 32'hFFFF_FFFF, 0);
    sm = save_msr;
    @(negedge clk);
    rfi_valid = 1;
    @(negedge clk);
    rfi_valid = 0;
    chk("R10", "done", 32'(done), 1);
    chk("R10", "fetch_pc", fetch_pc, 32'h0000_2FFC);
    chk("R10", "new_msr", new_msr, sm & ~MASK);
  endtask

  task automatic t_checkstop;
    logic [31:0] sp = save_pc;
    drive_req(1, 0, 32'h0000_A000, 32'h0000_0000, 0);
    chk("R7", "halted", 32'(halted), 1);
    chk("R7", "done", 32'(done), 0);
    chk("R7", "save_pc", save_pc, sp);
    drive_req(4, 0, 32'h0000_A100, 32'h0000_1000, 0);
    chk("R7", "done while halted", 32'(done), 0);
    chk("R7", "save_pc while halted", save_pc, sp);
    @(negedge clk);
    rfi_valid = 1;
    @(negedge clk);
    rfi_valid = 0;
    chk("R7", "rfi ignored", 32'(done), 0);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    chk("R1", "halted cleared", 32'(halted), 0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1;
    @(negedge clk);
    t_external();
    t_embedded();
    t_program();
    t_unavail();
    t_fp_drop();
    t_sysreset();
    t_undefined();
    t_rfi();
    t_checkstop();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule